// File: doc/BRIEF.md
# Calendar Timekeeping Counter Core

This block keeps wall-clock time and the calendar date in packed BCD. A one-cycle enable pulse, delivered once per second by external division logic, advances a chain of cascaded counters: seconds, minutes and hours, then day of week, day of month, month, year and century. The hour counter runs either from 00 to 23 or from 01 to 12 with a separate AM/PM flag. A mode input selects between the two. Month lengths follow the calendar, and February gains a 29th day whenever the year is a multiple of four.

Software sets the time or the date through a request/acknowledge handshake. Raising a request freezes the matching counters. The next second pulse sets an acknowledge flag, which stays set until a clear strobe arrives. Dropping the request loads the presented write word, and counting then resumes. Single-cycle event pulses mark minute, hour, midnight, noon, week, month and year changes so that neighbouring interrupt logic can use them.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time word reads 00:00:00 with the AM/PM bit clear. The calendar word reads century 20, year 00, month 01, day of week 1, day of month 01. The acknowledge flag and all event outputs are low.
- R2: The time word packs seconds in bits 6:0, minutes in bits 14:8, hour in bits 21:16 and the PM flag in bit 22, with all other bits zero. Each second pulse advances the seconds in BCD from 00 to 59. At 59 the seconds wrap to 00 and the minutes advance, also from 00 to 59.
- R3: With the mode input at 0, hours run 00 to 23 in BCD. A minute carry at hour 23 wraps to 00 (midnight), and one at hour 11 steps to 12 (noon).
- R4: With the mode input at 1, hours run 01 to 12. Hour 12 steps to 01. The step from 11 to 12 toggles the PM flag: from AM it is noon, from PM it is midnight.
- R5: The calendar word packs century in bits 6:0, year in bits 15:8, month in bits 20:16, day of week in bits 23:21 and day of month in bits 29:24. Midnight advances the day of month. The day wraps to 01 after 31, 30 (months 04, 06, 09, 11) or February's 28, which is 29 when the BCD year is divisible by 4. A wrap advances the month.
- R6: Day of week advances at each midnight from 1 to 7 and wraps 7 to 1.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and advances the century.
- R8: The event outputs pulse high for exactly the one cycle after the second pulse that caused the change. The events are minute change, hour change, midnight, noon, week wrap to day 1, month change and year change.
- R9: While the time request is high the time fields hold, and while the calendar request is high the calendar fields hold. A frozen calendar drops a midnight carry. In the cycle after a request falls, the matching word equals the write data presented at the falling edge.
- R10: The acknowledge flag sets in the cycle after a second pulse that arrives while either request is high. It stays set until a clear strobe arrives with no new set condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance enable, one cycle wide |
| mode_12h_i | input | 1 | 1 selects 12-hour counting, 0 selects 24-hour |
| upd_time_i | input | 1 | Time load request (level) |
| upd_cal_i | input | 1 | Calendar load request (level) |
| ack_clr_i | input | 1 | Write-one strobe clearing the acknowledge flag |
| time_wdata_i | input | 32 | Time word loaded when the time request falls |
| cal_wdata_i | input | 32 | Calendar word loaded when the calendar request falls |
| time_o | output | 32 | Packed time word |
| cal_o | output | 32 | Packed calendar word |
| ack_o | output | 1 | Update acknowledge flag |
| ev_min_o | output | 1 | Minute changed |
| ev_hour_o | output | 1 | Hour changed |
| ev_midnight_o | output | 1 | Midnight reached |
| ev_noon_o | output | 1 | Noon reached |
| ev_week_o | output | 1 | Day of week wrapped to 1 |
| ev_month_o | output | 1 | Month changed |
| ev_year_o | output | 1 | Year changed |

## Verification
Each vector loads a time word and a date through the handshake and then applies one second pulse. Preloads that sit just below a carry boundary show whether each counter wraps at the right BCD value and ripples only as far as it should. The vectors cover a plain seconds step, a BCD digit carry, noon and midnight in both hour modes, 30- and 31-day months, February in leap and non-leap years, and the year and century wrap. The event pulses are compared against the expected set and must drop one cycle later. Directed runs separate the freeze from the load, check that the acknowledge waits for a second pulse, and freeze only the calendar across midnight to show that the date holds while the time wraps.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int CENT_W = 7;
  localparam int YEAR_W = 8;
  localparam int MON_W  = 5;
  localparam int DOW_W  = 3;
  localparam int DATE_W = 6;
  localparam int WORD_W = 32;

  // word bit positions decoded by neighbouring logic
  localparam int SEC_LSB  = 0;
  localparam int MIN_LSB  = 8;
  localparam int HOUR_LSB = 16;
  localparam int PM_BIT   = 22;
  localparam int CENT_LSB = 0;
  localparam int YEAR_LSB = 8;
  localparam int MON_LSB  = 16;
  localparam int DOW_LSB  = 21;
  localparam int DATE_LSB = 24;

  typedef struct packed {
    logic              pm;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } tod_t;

  typedef struct packed {
    logic [CENT_W-1:0] cent;
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  mon;
    logic [DOW_W-1:0]  dow;
    logic [DATE_W-1:0] date;
  } cal_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'h1};
  endfunction

  // BCD year divisible by 4: even tens digit with 0/4/8, odd tens with 2/6
  function automatic logic is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
    else      return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
  endfunction

  function automatic logic [DATE_W-1:0] month_len(input logic [MON_W-1:0] m, input logic leap);
    case (m)
      5'h02:                      return leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_upd_ctrl.sv
module rtc_upd_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic upd_time_i,
  input  logic upd_cal_i,
  input  logic ack_clr_i,
  output logic freeze_time_o,
  output logic freeze_cal_o,
  output logic load_time_o,
  output logic load_cal_o,
  output logic ack_o
);
  localparam int NCH = 2;

  logic [NCH-1:0] req, load;
  logic           ack_q;

  assign req = {upd_cal_i, upd_time_i};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic req_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_q <= 1'b0;
      else         req_q <= req[g];
    end
    // load on request release
    assign load[g] = req_q & ~req[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ack_q <= 1'b0;
    else if (tick_i && |req)   ack_q <= 1'b1;
    else if (ack_clr_i)        ack_q <= 1'b0;
  end

  assign freeze_time_o = req[0];
  assign freeze_cal_o  = req[1];
  assign load_time_o   = load[0];
  assign load_cal_o    = load[1];
  assign ack_o         = ack_q;

  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !ack_clr_i) |=> ack_o); // R10
  AST_ACK_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(tick_i && (upd_time_i || upd_cal_i))); // R10

endmodule

// File: rtl/rtc_tod_counter.sv
module rtc_tod_counter
  import rtc_cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic mode_12h_i,
  input  logic freeze_i,
  input  logic load_i,
  input  tod_t wdata_i,
  output tod_t tod_o,
  output logic day_carry_o,
  output logic ev_min_o,
  output logic ev_hour_o,
  output logic ev_midnight_o,
  output logic ev_noon_o
);
  tod_t       tod_q, tod_d;
  logic       step, min_step, hour_step, midnight, noon;
  logic [7:0] sec_inc, min_inc, hour_inc;
  logic       ev_min_q, ev_hour_q, ev_mid_q, ev_noon_q;

  always_comb begin
    sec_inc   = bcd_inc({1'b0, tod_q.sec});
    min_inc   = bcd_inc({1'b0, tod_q.min});
    hour_inc  = bcd_inc({2'b0, tod_q.hour});
    step      = tick_i & ~freeze_i & ~load_i;
    min_step  = step & (tod_q.sec == 7'h59);
    hour_step = min_step & (tod_q.min == 7'h59);
    if (mode_12h_i) begin
      midnight = (tod_q.hour == 6'h11) &  tod_q.pm;
      noon     = (tod_q.hour == 6'h11) & ~tod_q.pm;
    end else begin
      midnight = (tod_q.hour == 6'h23);
      noon     = (tod_q.hour == 6'h11);
    end

    tod_d = tod_q;
    if (load_i) begin
      tod_d = wdata_i;
    end else if (step) begin
      tod_d.sec = (tod_q.sec == 7'h59) ? 7'h00 : sec_inc[SEC_W-1:0];
      if (min_step) tod_d.min = (tod_q.min == 7'h59) ? 7'h00 : min_inc[MIN_W-1:0];
      if (hour_step) begin
        if (mode_12h_i) begin
          tod_d.hour = (tod_q.hour == 6'h12) ? 6'h01 : hour_inc[HOUR_W-1:0];
          if (tod_q.hour == 6'h11) tod_d.pm = ~tod_q.pm;
        end else begin
          tod_d.hour = midnight ? 6'h00 : hour_inc[HOUR_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tod_q     <= '0;
      ev_min_q  <= 1'b0;
      ev_hour_q <= 1'b0;
      ev_mid_q  <= 1'b0;
      ev_noon_q <= 1'b0;
    end else begin
      tod_q     <= tod_d;
      ev_min_q  <= min_step;
      ev_hour_q <= hour_step;
      ev_mid_q  <= hour_step & midnight;
      ev_noon_q <= hour_step & noon;
    end
  end

  assign tod_o         = tod_q;
  assign day_carry_o   = hour_step & midnight;
  assign ev_min_o      = ev_min_q;
  assign ev_hour_o     = ev_hour_q;
  assign ev_midnight_o = ev_mid_q;
  assign ev_noon_o     = ev_noon_q;

  AST_TIME_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(tod_q)); // R9
  AST_MIDNIGHT_HOUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_midnight_o |-> (tod_q.hour == ($past(mode_12h_i) ? 6'h12 : 6'h00))); // R3
  AST_NOON_HOUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_noon_o |-> (tod_q.hour == 6'h12)); // R3
  AST_NOON_PM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_noon_o && $past(mode_12h_i)) |-> tod_q.pm); // R4

endmodule

// File: rtl/rtc_date_counter.sv
module rtc_date_counter
  import rtc_cal_pkg::*;
#(
  parameter logic [CENT_W-1:0] RST_CENT = 7'h20,
  parameter logic [YEAR_W-1:0] RST_YEAR = 8'h00,
  parameter logic [MON_W-1:0]  RST_MON  = 5'h01,
  parameter logic [DOW_W-1:0]  RST_DOW  = 3'd1,
  parameter logic [DATE_W-1:0] RST_DATE = 6'h01
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic day_inc_i,
  input  logic freeze_i,
  input  logic load_i,
  input  cal_t wdata_i,
  output cal_t cal_o,
  output logic ev_week_o,
  output logic ev_month_o,
  output logic ev_year_o
);
  localparam logic [DOW_W-1:0] DOW_LAST = 3'd7;

  cal_t       cal_q, cal_d;
  logic       step, date_wrap, mon_step, year_step;
  logic [7:0] date_inc, mon_inc, year_inc, cent_inc;
  logic       ev_week_q, ev_mon_q, ev_year_q;

  always_comb begin
    date_inc  = bcd_inc({2'b0, cal_q.date});
    mon_inc   = bcd_inc({3'b0, cal_q.mon});
    year_inc  = bcd_inc(cal_q.year);
    cent_inc  = bcd_inc({1'b0, cal_q.cent});
    step      = day_inc_i & ~freeze_i & ~load_i;
    date_wrap = (cal_q.date == month_len(cal_q.mon, is_leap(cal_q.year)));
    mon_step  = step & date_wrap;
    year_step = mon_step & (cal_q.mon == 5'h12);

    cal_d = cal_q;
    if (load_i) begin
      cal_d = wdata_i;
    end else if (step) begin
      cal_d.dow  = (cal_q.dow == DOW_LAST) ? 3'd1 : cal_q.dow + 3'd1;
      cal_d.date = date_wrap ? 6'h01 : date_inc[DATE_W-1:0];
      if (mon_step) cal_d.mon = (cal_q.mon == 5'h12) ? 5'h01 : mon_inc[MON_W-1:0];
      if (year_step) begin
        cal_d.year = (cal_q.year == 8'h99) ? 8'h00 : year_inc;
        if (cal_q.year == 8'h99) cal_d.cent = cent_inc[CENT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q     <= '{cent: RST_CENT, year: RST_YEAR, mon: RST_MON, dow: RST_DOW, date: RST_DATE};
      ev_week_q <= 1'b0;
      ev_mon_q  <= 1'b0;
      ev_year_q <= 1'b0;
    end else begin
      cal_q     <= cal_d;
      ev_week_q <= step & (cal_q.dow == DOW_LAST);
      ev_mon_q  <= mon_step;
      ev_year_q <= year_step;
    end
  end

  assign cal_o      = cal_q;
  assign ev_week_o  = ev_week_q;
  assign ev_month_o = ev_mon_q;
  assign ev_year_o  = ev_year_q;

  AST_CAL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(cal_q)); // R9
  AST_WEEK_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_week_o |-> (cal_q.dow == 3'd1)); // R6
  AST_MONTH_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_month_o |-> (cal_q.date == 6'h01)); // R5
  AST_YEAR_JAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_year_o |-> (cal_q.mon == 5'h01)); // R7

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter logic [CENT_W-1:0] RST_CENT = 7'h20,
  parameter logic [YEAR_W-1:0] RST_YEAR = 8'h00,
  parameter logic [MON_W-1:0]  RST_MON  = 5'h01,
  parameter logic [DOW_W-1:0]  RST_DOW  = 3'd1,
  parameter logic [DATE_W-1:0] RST_DATE = 6'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              mode_12h_i,
  input  logic              upd_time_i,
  input  logic              upd_cal_i,
  input  logic              ack_clr_i,
  input  logic [WORD_W-1:0] time_wdata_i,
  input  logic [WORD_W-1:0] cal_wdata_i,
  output logic [WORD_W-1:0] time_o,
  output logic [WORD_W-1:0] cal_o,
  output logic              ack_o,
  output logic              ev_min_o,
  output logic              ev_hour_o,
  output logic              ev_midnight_o,
  output logic              ev_noon_o,
  output logic              ev_week_o,
  output logic              ev_month_o,
  output logic              ev_year_o
);
  logic freeze_time, freeze_cal, load_time, load_cal, day_carry;
  tod_t tod_wr, tod;
  cal_t cal_wr, cal;
  logic unused_wdata;

  always_comb begin
    tod_wr.sec  = time_wdata_i[SEC_LSB  +: SEC_W];
    tod_wr.min  = time_wdata_i[MIN_LSB  +: MIN_W];
    tod_wr.hour = time_wdata_i[HOUR_LSB +: HOUR_W];
    tod_wr.pm   = time_wdata_i[PM_BIT];
    cal_wr.cent = cal_wdata_i[CENT_LSB +: CENT_W];
    cal_wr.year = cal_wdata_i[YEAR_LSB +: YEAR_W];
    cal_wr.mon  = cal_wdata_i[MON_LSB  +: MON_W];
    cal_wr.dow  = cal_wdata_i[DOW_LSB  +: DOW_W];
    cal_wr.date = cal_wdata_i[DATE_LSB +: DATE_W];
  end

  assign unused_wdata = ^{time_wdata_i[31:23], time_wdata_i[15], time_wdata_i[7],
                          cal_wdata_i[31:30], cal_wdata_i[7]};

  rtc_upd_ctrl u_upd (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .upd_time_i    (upd_time_i),
    .upd_cal_i     (upd_cal_i),
    .ack_clr_i     (ack_clr_i),
    .freeze_time_o (freeze_time),
    .freeze_cal_o  (freeze_cal),
    .load_time_o   (load_time),
    .load_cal_o    (load_cal),
    .ack_o         (ack_o)
  );

  rtc_tod_counter u_tod (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .mode_12h_i    (mode_12h_i),
    .freeze_i      (freeze_time),
    .load_i        (load_time),
    .wdata_i       (tod_wr),
    .tod_o         (tod),
    .day_carry_o   (day_carry),
    .ev_min_o      (ev_min_o),
    .ev_hour_o     (ev_hour_o),
    .ev_midnight_o (ev_midnight_o),
    .ev_noon_o     (ev_noon_o)
  );

  rtc_date_counter #(
    .RST_CENT (RST_CENT),
    .RST_YEAR (RST_YEAR),
    .RST_MON  (RST_MON),
    .RST_DOW  (RST_DOW),
    .RST_DATE (RST_DATE)
  ) u_date (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .day_inc_i  (day_carry),
    .freeze_i   (freeze_cal),
    .load_i     (load_cal),
    .wdata_i    (cal_wr),
    .cal_o      (cal),
    .ev_week_o  (ev_week_o),
    .ev_month_o (ev_month_o),
    .ev_year_o  (ev_year_o)
  );

  always_comb begin
    time_o = '0;
    time_o[SEC_LSB  +: SEC_W]  = tod.sec;
    time_o[MIN_LSB  +: MIN_W]  = tod.min;
    time_o[HOUR_LSB +: HOUR_W] = tod.hour;
    time_o[PM_BIT]             = tod.pm;
    cal_o = '0;
    cal_o[CENT_LSB +: CENT_W] = cal.cent;
    cal_o[YEAR_LSB +: YEAR_W] = cal.year;
    cal_o[MON_LSB  +: MON_W]  = cal.mon;
    cal_o[DOW_LSB  +: DOW_W]  = cal.dow;
    cal_o[DATE_LSB +: DATE_W] = cal.date;
  end

endmodule

// File: tb/rtc_calendar_core_bench.sv
`timescale 1ns/1ps
module rtc_calendar_core_bench;

  function automatic logic [31:0] mk_time(input logic [7:0] h, m, s, input logic pm);
    return {9'b0, pm, h[5:0], 1'b0, m[6:0], 1'b0, s[6:0]};
  endfunction

  function automatic logic [31:0] mk_cal(input logic [7:0] c, y, mo, input logic [2:0] dw,
                                         input logic [7:0] d);
    return {2'b0, d[5:0], dw, mo[4:0], y, 1'b0, c[6:0]};
  endfunction

  // ev bits: 0 min, 1 hour, 2 midnight, 3 noon, 4 week, 5 month, 6 year
  typedef struct packed {
    logic [15:0] tag;
    logic        mode;
    logic [31:0] t_in;
    logic [31:0] c_in;
    logic [31:0] t_exp;
    logic [31:0] c_exp;
    logic [6:0]  ev;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{"R2", 1'b0, mk_time(8'h00,8'h00,8'h00,1'b0), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01),
              mk_time(8'h00,8'h00,8'h01,1'b0), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01), 7'h00},
    '{"R2", 1'b0, mk_time(8'h00,8'h00,8'h59,1'b0), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01),
              mk_time(8'h00,8'h01,8'h00,1'b0), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01), 7'h01},
    '{"R3", 1'b0, mk_time(8'h10,8'h59,8'h59,1'b0), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01),
              mk_time(8'h11,8'h00,8'h00,1'b0), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01), 7'h03},
    '{"R3", 1'b0, mk_time(8'h11,8'h59,8'h59,1'b0), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01),
              mk_time(8'h12,8'h00,8'h00,1'b0), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01), 7'h0B},
    '{"R5", 1'b0, mk_time(8'h23,8'h59,8'h59,1'b0), mk_cal(8'h20,8'h23,8'h02,3'd3,8'h28),
              mk_time(8'h00,8'h00,8'h00,1'b0), mk_cal(8'h20,8'h23,8'h03,3'd4,8'h01), 7'h27},
    '{"R6", 1'b0, mk_time(8'h23,8'h59,8'h59,1'b0), mk_cal(8'h20,8'h24,8'h02,3'd7,8'h28),
              mk_time(8'h00,8'h00,8'h00,1'b0), mk_cal(8'h20,8'h24,8'h02,3'd1,8'h29), 7'h17},
    '{"R5", 1'b0, mk_time(8'h23,8'h59,8'h59,1'b0), mk_cal(8'h20,8'h24,8'h02,3'd2,8'h29),
              mk_time(8'h00,8'h00,8'h00,1'b0), mk_cal(8'h20,8'h24,8'h03,3'd3,8'h01), 7'h27},
    '{"R7", 1'b0, mk_time(8'h23,8'h59,8'h59,1'b0), mk_cal(8'h20,8'h99,8'h12,3'd5,8'h31),
              mk_time(8'h00,8'h00,8'h00,1'b0), mk_cal(8'h21,8'h00,8'h01,3'd6,8'h01), 7'h67},
    '{"R5", 1'b0, mk_time(8'h23,8'h59,8'h59,1'b0), mk_cal(8'h20,8'h21,8'h04,3'd1,8'h30),
              mk_time(8'h00,8'h00,8'h00,1'b0), mk_cal(8'h20,8'h21,8'h05,3'd2,8'h01), 7'h27},
    '{"R5", 1'b0, mk_time(8'h23,8'h59,8'h59,1'b0), mk_cal(8'h20,8'h21,8'h04,3'd1,8'h29),
              mk_time(8'h00,8'h00,8'h00,1'b0), mk_cal(8'h20,8'h21,8'h04,3'd2,8'h30), 7'h07},
    '{"R4", 1'b1, mk_time(8'h11,8'h59,8'h59,1'b0), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01),
              mk_time(8'h12,8'h00,8'h00,1'b1), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01), 7'h0B},
    '{"R4", 1'b1, mk_time(8'h12,8'h59,8'h59,1'b1), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01),
              mk_time(8'h01,8'h00,8'h00,1'b1), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01), 7'h03},
    '{"R4", 1'b1, mk_time(8'h11,8'h59,8'h59,1'b1), mk_cal(8'h20,8'h00,8'h02,3'd1,8'h28),
              mk_time(8'h12,8'h00,8'h00,1'b0), mk_cal(8'h20,8'h00,8'h02,3'd2,8'h29), 7'h07},
    '{"R4", 1'b1, mk_time(8'h09,8'h59,8'h59,1'b0), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01),
              mk_time(8'h10,8'h00,8'h00,1'b0), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01), 7'h03},
    '{"R3", 1'b0, mk_time(8'h19,8'h59,8'h59,1'b0), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01),
              mk_time(8'h20,8'h00,8'h00,1'b0), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01), 7'h03},
    '{"R2", 1'b0, mk_time(8'h00,8'h09,8'h09,1'b0), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01),
              mk_time(8'h00,8'h09,8'h10,1'b0), mk_cal(8'h20,8'h00,8'h01,3'd1,8'h01), 7'h00},
    '{"R5", 1'b0, mk_time(8'h23,8'h59,8'h59,1'b0), mk_cal(8'h20,8'h10,8'h09,3'd4,8'h30),
              mk_time(8'h00,8'h00,8'h00,1'b0), mk_cal(8'h20,8'h10,8'h10,3'd5,8'h01), 7'h27},
    '{"R7", 1'b0, mk_time(8'h23,8'h59,8'h59,1'b0), mk_cal(8'h20,8'h19,8'h12,3'd2,8'h31),
              mk_time(8'h00,8'h00,8'h00,1'b0), mk_cal(8'h20,8'h20,8'h01,3'd3,8'h01), 7'h67}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        mode_12h_i = 1'b0;
  logic        upd_time_i = 1'b0;
  logic        upd_cal_i = 1'b0;
  logic        ack_clr_i = 1'b0;
  logic [31:0] time_wdata_i = '0;
  logic [31:0] cal_wdata_i = '0;
  logic [31:0] time_o, cal_o;
  logic        ack_o;
  logic        ev_min_o, ev_hour_o, ev_midnight_o, ev_noon_o, ev_week_o, ev_month_o, ev_year_o;
  logic [6:0]  ev_w;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] t_hold, c_hold;

  assign ev_w = {ev_year_o, ev_month_o, ev_week_o, ev_noon_o, ev_midnight_o, ev_hour_o, ev_min_o};

  always #10 clk_i = ~clk_i;

  rtc_calendar_core u_rtc_calendar_core (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .mode_12h_i    (mode_12h_i),
    .upd_time_i    (upd_time_i),
    .upd_cal_i     (upd_cal_i),
    .ack_clr_i     (ack_clr_i),
    .time_wdata_i  (time_wdata_i),
    .cal_wdata_i   (cal_wdata_i),
    .time_o        (time_o),
    .cal_o         (cal_o),
    .ack_o         (ack_o),
    .ev_min_o      (ev_min_o),
    .ev_hour_o     (ev_hour_o),
    .ev_midnight_o (ev_midnight_o),
    .ev_noon_o     (ev_noon_o),
    .ev_week_o     (ev_week_o),
    .ev_month_o    (ev_month_o),
    .ev_year_o     (ev_year_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic load_words(input logic [31:0] t, input logic [31:0] c);
    @(negedge clk_i);
    time_wdata_i = t; cal_wdata_i = c;
    upd_time_i = 1'b1; upd_cal_i = 1'b1;
    do_tick();
    @(negedge clk_i); upd_time_i = 1'b0; upd_cal_i = 1'b0;
    @(negedge clk_i); ack_clr_i = 1'b1;
    @(negedge clk_i); ack_clr_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", "time", time_o, mk_time(8'h00, 8'h00, 8'h00, 1'b0));
    chk("R1", "cal", cal_o, mk_cal(8'h20, 8'h00, 8'h01, 3'd1, 8'h01));
    chk("R1", "ack", {31'b0, ack_o}, 32'd0);
    chk("R1", "events", {25'b0, ev_w}, 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i); mode_12h_i = VECS[i].mode;
      load_words(VECS[i].t_in, VECS[i].c_in);
      do_tick();
      chk(string'(VECS[i].tag), "time", time_o, VECS[i].t_exp);
      chk(string'(VECS[i].tag), "cal", cal_o, VECS[i].c_exp);
      chk("R8", "events", {25'b0, ev_w}, {25'b0, VECS[i].ev});
      @(negedge clk_i);
      chk("R8", "events drop", {25'b0, ev_w}, 32'd0);
    end

    // R10 / R9: ack waits for tick, freeze holds, load on release
    @(negedge clk_i); mode_12h_i = 1'b0;
    upd_time_i = 1'b1; time_wdata_i = mk_time(8'h12, 8'h34, 8'h56, 1'b0);
    repeat (3) @(negedge clk_i);
    chk("R10", "ack before tick", {31'b0, ack_o}, 32'd0);
    t_hold = time_o;
    do_tick();
    chk("R10", "ack after tick", {31'b0, ack_o}, 32'd1);
    chk("R9", "frozen time", time_o, t_hold);
    do_tick();
    chk("R9", "frozen time 2", time_o, t_hold);
    @(negedge clk_i); upd_time_i = 1'b0;
    @(negedge clk_i);
    chk("R9", "loaded time", time_o, mk_time(8'h12, 8'h34, 8'h56, 1'b0));
    chk("R10", "ack held", {31'b0, ack_o}, 32'd1);
    @(negedge clk_i); ack_clr_i = 1'b1;
    @(negedge clk_i); ack_clr_i = 1'b0;
    chk("R10", "ack cleared", {31'b0, ack_o}, 32'd0);

    // R9: calendar frozen across midnight while time wraps
    load_words(mk_time(8'h23, 8'h59, 8'h59, 1'b0), mk_cal(8'h20, 8'h21, 8'h03, 3'd2, 8'h15));
    @(negedge clk_i);
    upd_cal_i = 1'b1; cal_wdata_i = mk_cal(8'h20, 8'h21, 8'h06, 3'd5, 8'h10);
    c_hold = cal_o;
    do_tick();
    chk("R9", "time wraps", time_o, mk_time(8'h00, 8'h00, 8'h00, 1'b0));
    chk("R9", "cal frozen", cal_o, c_hold);
    chk("R8", "midnight pulse", {31'b0, ev_midnight_o}, 32'd1);
    @(negedge clk_i); upd_cal_i = 1'b0;
    @(negedge clk_i);
    chk("R9", "loaded cal", cal_o, mk_cal(8'h20, 8'h21, 8'h06, 3'd5, 8'h10));
    @(negedge clk_i); ack_clr_i = 1'b1;
    @(negedge clk_i); ack_clr_i = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule